// File: doc/BRIEF.md
# Transceiver Interrupt Status and Latch Register Bank

This block is a small read-only register bank for a USB transceiver. It watches four comparator and detector inputs: session end, session valid, VBUS valid and host disconnect. These inputs arrive asynchronously, so each one passes through a flop synchronizer. The synchronized values are readable as a live status byte. Two 4-bit enable masks, one for rising edges and one for falling edges, are inputs to the block. Each transition allowed by a mask sets a sticky bit in a latch byte.

The whole latch byte clears at once when the link reads it, and again when the transceiver enters low-power mode. An event that lands in the same cycle as either clear is kept, so no event is lost. A third byte exposes the present two-bit line state for debug.

Reads use a one-cycle strobe with an address. The selected byte appears on the data output one clock later and stays there until the next strobe.

Top module: `phy_irq_regs`

## Requirements
- R1: A read of address 13h returns the synchronized live source values in bits 3..0: bit 3 session end, bit 2 session valid, bit 1 VBUS valid, bit 0 host disconnect. Bits 7..4 read 0.
- R2: Each source passes through a two-flop synchronizer. A read whose strobe edge falls one or two clock edges after the input change still returns the old value. The new value is returned from the third edge on.
- R3: A 0-to-1 transition of a synchronized source sets its bit in the latch byte at address 14h only when the matching bit of the rising-edge mask is 1. The latch byte uses the same bit order as R1.
- R4: A 1-to-0 transition sets the matching latch bit only when the matching bit of the falling-edge mask is 1.
- R5: Transitions whose mask bit is 0 leave the latch byte unchanged.
- R6: A read of 14h returns the latch byte and clears all latch bits in the same edge.
- R7: An enabled event that occurs in the same cycle as a clearing read of 14h is not lost. The read returns the earlier contents, and the event's bit stays set afterwards.
- R8: A 0-to-1 transition of the low-power input clears all latch bits. While low-power stays high, new events latch normally.
- R9: A read of 15h returns the current line state in bits 1..0 and 0 in bits 7..2.
- R10: A strobe registers the selected byte on the next edge. The output holds its value while no strobe is present. Any address other than 13h, 14h and 15h returns 00h.
- R11: After reset, the output and every register bit are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_async | input | 4 | Raw sources: [3] session end, [2] session valid, [1] VBUS valid, [0] host disconnect |
| line_state | input | 2 | Present line state shown in the debug byte |
| low_power | input | 1 | High while the transceiver is in low-power mode |
| rise_en | input | 4 | Per-source enable for 0-to-1 events |
| fall_en | input | 4 | Per-source enable for 1-to-0 events |
| rd_stb | input | 1 | One-cycle read strobe |
| rd_addr | input | 8 | Read address |
| rd_data | output | 8 | Read data, valid the cycle after the strobe |

## Verification
The bench fires a clearing read in exactly the cycle in which an enabled edge is seen. A design where the clear takes priority would drop that bit and read 00h afterwards.

Back-to-back status reads across an input change check the synchronizer depth. Too few stages would show the new value one or two reads early.

Masked-off edges in each direction are checked to leave the latch byte at zero. Low-power is held high across a later event to show that only its entry clears. A level-triggered clear would hide that event.

Unmapped addresses, and the holding of the output between strobes, catch a decoder that falls through to a live register.

// File: rtl/phy_irq_pkg.sv
package phy_irq_pkg;

   typedef enum logic [1:0] {
      SEL_NONE   = 2'd0,
      SEL_STATUS = 2'd1,
      SEL_LATCH  = 2'd2,
      SEL_DEBUG  = 2'd3
   } reg_sel_e;

   function automatic logic [1:0] edge_kind(input logic now_v, input logic prev_v);
      // [1] rising, [0] falling
      return {now_v & ~prev_v, ~now_v & prev_v};
   endfunction

endpackage

// File: rtl/phy_irq_sync.sv
module phy_irq_sync #(
   parameter int WIDTH  = 4,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_async,
   output logic [WIDTH-1:0] q_sync
);

   if (STAGES < 2) begin : g_bad_stages
      $error("phy_irq_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("phy_irq_sync: WIDTH must be positive");
   end

   logic [WIDTH-1:0] chain_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (!rst_n) chain_q[s] <= '0;
            else        chain_q[s] <= d_async;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (!rst_n) chain_q[s] <= '0;
            else        chain_q[s] <= chain_q[s-1];
         end
      end
   end

   assign q_sync = chain_q[STAGES-1];

endmodule

// File: rtl/phy_irq_edge_latch.sv
module phy_irq_edge_latch
   import phy_irq_pkg::*;
#(
   parameter int NUM_SRC = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] live_i,
   input  logic [NUM_SRC-1:0] rise_en_i,
   input  logic [NUM_SRC-1:0] fall_en_i,
   input  logic               rd_clr_i,
   input  logic               low_power_i,
   output logic [NUM_SRC-1:0] lat_o
);

   if (NUM_SRC < 1) begin : g_bad_num
      $error("phy_irq_edge_latch: NUM_SRC must be positive");
   end

   logic [NUM_SRC-1:0] prev_q;
   logic [NUM_SRC-1:0] evt;
   logic [NUM_SRC-1:0] lat_q;
   logic               lp_prev_q;
   logic               lp_enter;
   logic               clr_all;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_q    <= '0;
         lp_prev_q <= 1'b0;
      end else begin
         prev_q    <= live_i;
         lp_prev_q <= low_power_i;
      end
   end

   assign lp_enter = low_power_i & ~lp_prev_q;
   assign clr_all  = rd_clr_i | lp_enter;

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
      logic [1:0] kind;
      assign kind   = edge_kind(live_i[i], prev_q[i]);
      assign evt[i] = (kind[1] & rise_en_i[i]) | (kind[0] & fall_en_i[i]);

      // new event outranks clear
      always_ff @(posedge clk) begin
         if (!rst_n)         lat_q[i] <= 1'b0;
         else if (evt[i])    lat_q[i] <= 1'b1;
         else if (clr_all)   lat_q[i] <= 1'b0;
      end

      AST_LAT_SET: assert property (@(posedge clk) disable iff (!rst_n)
         evt[i] |=> lat_q[i]);                                   // R3
      AST_LAT_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(lat_q[i]) |-> $past(evt[i]));                     // R5
   end

   assign lat_o = lat_q;

   AST_RD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_clr_i && evt == '0) |=> lat_q == '0);                  // R6
   AST_LP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (low_power_i && !lp_prev_q && evt == '0) |=> lat_q == '0); // R8

endmodule

// File: rtl/phy_irq_rd_port.sv
module phy_irq_rd_port
   import phy_irq_pkg::*;
#(
   parameter int NUM_SRC   = 4,
   parameter int LINE_W    = 2,
   parameter int ADDR_W    = 8,
   parameter int DATA_W    = 8,
   parameter logic [ADDR_W-1:0] ADDR_STATUS = 'h13,
   parameter logic [ADDR_W-1:0] ADDR_LATCH  = 'h14,
   parameter logic [ADDR_W-1:0] ADDR_DEBUG  = 'h15
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               rd_stb_i,
   input  logic [ADDR_W-1:0]  rd_addr_i,
   input  logic [NUM_SRC-1:0] status_i,
   input  logic [NUM_SRC-1:0] latch_i,
   input  logic [LINE_W-1:0]  line_i,
   output logic               latch_clr_o,
   output logic [DATA_W-1:0]  rd_data_o
);

   if (NUM_SRC > DATA_W || LINE_W > DATA_W) begin : g_bad_fit
      $error("phy_irq_rd_port: register fields exceed DATA_W");
   end
   if (ADDR_STATUS == ADDR_LATCH || ADDR_STATUS == ADDR_DEBUG || ADDR_LATCH == ADDR_DEBUG)
   begin : g_bad_map
      $error("phy_irq_rd_port: register addresses must differ");
   end

   reg_sel_e          sel;
   logic [DATA_W-1:0] mux_d;
   logic [DATA_W-1:0] data_q;

   always_comb begin
      if      (rd_addr_i == ADDR_STATUS) sel = SEL_STATUS;
      else if (rd_addr_i == ADDR_LATCH)  sel = SEL_LATCH;
      else if (rd_addr_i == ADDR_DEBUG)  sel = SEL_DEBUG;
      else                               sel = SEL_NONE;
   end

   always_comb begin
      unique case (sel)
         SEL_STATUS: mux_d = DATA_W'(status_i);
         SEL_LATCH:  mux_d = DATA_W'(latch_i);
         SEL_DEBUG:  mux_d = DATA_W'(line_i);
         default:    mux_d = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n)        data_q <= '0;
      else if (rd_stb_i) data_q <= mux_d;
   end

   assign latch_clr_o = rd_stb_i && (sel == SEL_LATCH);
   assign rd_data_o   = data_q;

   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_stb_i |=> $stable(rd_data_o));                                 // R10
   AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb_i && rd_addr_i != ADDR_STATUS && rd_addr_i != ADDR_LATCH
       && rd_addr_i != ADDR_DEBUG) |=> rd_data_o == '0);                 // R10
   AST_STATUS_RSVD: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb_i && rd_addr_i == ADDR_STATUS) |=> rd_data_o[DATA_W-1:NUM_SRC] == '0); // R1
   AST_DEBUG_RSVD: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb_i && rd_addr_i == ADDR_DEBUG) |=> rd_data_o[DATA_W-1:LINE_W] == '0);   // R9

endmodule

// File: rtl/phy_irq_regs.sv
module phy_irq_regs #(
   parameter int NUM_SRC     = 4,
   parameter int LINE_W      = 2,
   parameter int ADDR_W      = 8,
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter logic [ADDR_W-1:0] ADDR_STATUS = 'h13,
   parameter logic [ADDR_W-1:0] ADDR_LATCH  = 'h14,
   parameter logic [ADDR_W-1:0] ADDR_DEBUG  = 'h15
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_async,
   input  logic [LINE_W-1:0]  line_state,
   input  logic               low_power,
   input  logic [NUM_SRC-1:0] rise_en,
   input  logic [NUM_SRC-1:0] fall_en,
   input  logic               rd_stb,
   input  logic [ADDR_W-1:0]  rd_addr,
   output logic [DATA_W-1:0]  rd_data
);

   logic [NUM_SRC-1:0] live;
   logic [NUM_SRC-1:0] lat;
   logic               lat_clr;

   phy_irq_sync #(
      .WIDTH  (NUM_SRC),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (src_async),
      .q_sync  (live)
   );

   phy_irq_edge_latch #(
      .NUM_SRC (NUM_SRC)
   ) u_latch (
      .clk         (clk),
      .rst_n       (rst_n),
      .live_i      (live),
      .rise_en_i   (rise_en),
      .fall_en_i   (fall_en),
      .rd_clr_i    (lat_clr),
      .low_power_i (low_power),
      .lat_o       (lat)
   );

   phy_irq_rd_port #(
      .NUM_SRC     (NUM_SRC),
      .LINE_W      (LINE_W),
      .ADDR_W      (ADDR_W),
      .DATA_W      (DATA_W),
      .ADDR_STATUS (ADDR_STATUS),
      .ADDR_LATCH  (ADDR_LATCH),
      .ADDR_DEBUG  (ADDR_DEBUG)
   ) u_rd (
      .clk         (clk),
      .rst_n       (rst_n),
      .rd_stb_i    (rd_stb),
      .rd_addr_i   (rd_addr),
      .status_i    (live),
      .latch_i     (lat),
      .line_i      (line_state),
      .latch_clr_o (lat_clr),
      .rd_data_o   (rd_data)
   );

   AST_READ_CLEARS_PORT: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb && rd_addr == ADDR_LATCH && lat != '0) |=> rd_data != '0);   // R6

endmodule

// File: tb/phy_irq_regs_tb.sv
`timescale 1ns/1ps
module phy_irq_regs_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] src_async = '0;
   logic [1:0] line_state = '0;
   logic       low_power = 1'b0;
   logic [3:0] rise_en = '0;
   logic [3:0] fall_en = '0;
   logic       rd_stb = 1'b0;
   logic [7:0] rd_addr = '0;
   logic [7:0] rd_data;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   phy_irq_regs dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .src_async  (src_async),
      .line_state (line_state),
      .low_power  (low_power),
      .rise_en    (rise_en),
      .fall_en    (fall_en),
      .rd_stb     (rd_stb),
      .rd_addr    (rd_addr),
      .rd_data    (rd_data)
   );

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %02h expected %02h", req, act, exp);
      end
   endtask

   task automatic rd(input logic [7:0] a, output logic [7:0] v);
      @(negedge clk);
      rd_stb  = 1'b1;
      rd_addr = a;
      @(posedge clk);
      @(negedge clk);
      rd_stb  = 1'b0;
      v = rd_data;
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) @(negedge clk);
   endtask

   task automatic set_src(input logic [3:0] v);
      @(negedge clk);
      src_async = v;
      idle(4);
   endtask

   task automatic t_reset();
      logic [7:0] v;
      check("R11 output", rd_data, 8'h00);
      rd(8'h13, v); check("R11 status", v, 8'h00);
      rd(8'h14, v); check("R11 latch", v, 8'h00);
      rd(8'h15, v); check("R11 debug", v, 8'h00);
   endtask

   task automatic t_status();
      logic [7:0] v;
      rise_en = '0; fall_en = '0;
      set_src(4'b1010);
      rd(8'h13, v); check("R1 status 1010", v, 8'h0A);
      set_src(4'b0101);
      rd(8'h13, v); check("R1 status 0101", v, 8'h05);
      // R2: three back-to-back reads straddling a change
      @(negedge clk);
      src_async = 4'b1111;
      rd_stb = 1'b1; rd_addr = 8'h13;
      @(posedge clk); @(negedge clk); check("R2 edge 1", rd_data, 8'h05);
      @(posedge clk); @(negedge clk); check("R2 edge 2", rd_data, 8'h05);
      @(posedge clk); @(negedge clk); check("R2 edge 3", rd_data, 8'h0F);
      rd_stb = 1'b0;
      rd(8'h14, v); check("R5 no masks", v, 8'h00);
   endtask

   task automatic t_rise_fall();
      logic [7:0] v;
      set_src(4'b0000);
      rd(8'h14, v);
      rise_en = 4'b1111; fall_en = 4'b0000;
      set_src(4'b1010);
      rd(8'h14, v); check("R3 rise all", v, 8'h0A);
      rd(8'h14, v); check("R6 cleared", v, 8'h00);
      set_src(4'b0000);
      rd(8'h14, v); check("R5 fall masked", v, 8'h00);
      rise_en = 4'b0001;
      set_src(4'b1111);
      rd(8'h14, v); check("R3 rise partial", v, 8'h01);
      rise_en = 4'b0000; fall_en = 4'b0100;
      set_src(4'b0000);
      rd(8'h14, v); check("R4 fall bit2", v, 8'h04);
      set_src(4'b1111);
      rd(8'h14, v); check("R5 rise masked", v, 8'h00);
      set_src(4'b0000);
      rd(8'h14, v);
   endtask

   task automatic t_collide();
      logic [7:0] v;
      rise_en = 4'b1111; fall_en = 4'b0000;
      rd(8'h14, v);
      @(negedge clk);
      src_async = 4'b0010;
      @(posedge clk); @(negedge clk);
      @(posedge clk); @(negedge clk);
      rd_stb = 1'b1; rd_addr = 8'h14;
      @(posedge clk); @(negedge clk);
      rd_stb = 1'b0;
      check("R7 read returns old", rd_data, 8'h00);
      rd(8'h14, v); check("R7 event kept", v, 8'h02);
      rd(8'h14, v); check("R6 clear after", v, 8'h00);
   endtask

   task automatic t_lowpower();
      logic [7:0] v;
      rise_en = 4'b1111; fall_en = 4'b0000;
      set_src(4'b0000);
      rd(8'h14, v);
      set_src(4'b1000);
      @(negedge clk); low_power = 1'b1;
      idle(3);
      rd(8'h14, v); check("R8 entry clears", v, 8'h00);
      set_src(4'b1001);
      rd(8'h14, v); check("R8 held latches", v, 8'h01);
      @(negedge clk); low_power = 1'b0;
      set_src(4'b0000);
      rd(8'h14, v);
   endtask

   task automatic t_debug();
      logic [7:0] v;
      line_state = 2'b10; rd(8'h15, v); check("R9 line 10", v, 8'h02);
      line_state = 2'b01; rd(8'h15, v); check("R9 line 01", v, 8'h01);
      line_state = 2'b11; rd(8'h15, v); check("R9 line 11", v, 8'h03);
   endtask

   task automatic t_map();
      logic [7:0] v;
      rise_en = '0; fall_en = '0;
      set_src(4'b1100);
      rd(8'h12, v); check("R10 addr 12", v, 8'h00);
      rd(8'h16, v); check("R10 addr 16", v, 8'h00);
      rd(8'hFF, v); check("R10 addr FF", v, 8'h00);
      rd(8'h13, v); check("R1 status 1100", v, 8'h0C);
      @(negedge clk); rd_addr = 8'h15;
      src_async = 4'b0011;
      idle(5);
      check("R10 holds", rd_data, 8'h0C);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      idle(3);
      @(negedge clk); rst_n = 1'b1;
      t_reset();
      t_status();
      t_rise_fall();
      t_collide();
      t_lowpower();
      t_debug();
      t_map();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end

endmodule